// File: doc/BRIEF.md
# Digital Receive AGC Loop

This block closes a digital gain-control loop around a stream of signed receive samples. Each accepted sample first passes through a DC-tracking high-pass stage. The filtered sample is squared, and its power is summed over a programmable number of samples. At the end of each interval, a shift picks a window of the power sum and a constant is subtracted from it. The result addresses a 64-entry error table. The error, scaled by a programmable shift, is added to an unsigned 16-bit gain word. The gain word multiplies the filtered samples on their way out.

The loop is armed by a sync pulse. The sync pulse is delayed by a set number of valid samples. Once armed, the loop performs a set number of gain updates, or runs without limit if that number is zero. A second delay line lets the gain seen by the multiplier lag the gain word by a chosen number of samples.

Top module: `rx_agc_loop`

## Requirements
- R1: After reset, `gain_o` is 0x4000, which is unity with 14 fractional bits. `smp_vld_o` is 0 and `smp_o` is 0.
- R2: Until the first effective sync, the gain word never changes, whatever samples arrive.
- R3: A sync is taken only on a cycle where `smp_vld_i` is high. It becomes effective on the valid sample that comes `sync_dly_i` valid samples later. With a delay of 0, it becomes effective on the same sample. The effective sample is the first sample of a new interval.
- R4: The gain is updated on the last sample of each interval of `int_len_i` valid samples. The new value shows on `gain_o` two clock cycles after that sample is presented. An `int_len_i` of 0 acts as 1.
- R5: After an effective sync, exactly `upd_cnt_i` updates take place, then the loop goes idle. A value of 0 gives updates without end. A new effective sync clears the power sum and the interval count, and reloads the update count.
- R6: The filter output is y = x − floor(d / 2^10). The state d is updated after each valid sample as d += (x·2^10 − d) >>> (10 − `hp_code_i`), with arithmetic shift. d is 0 after reset, so the first output equals the input. A larger code removes a DC step faster.
- R7: The table address is floor(P / 2^(48 − `pwr_shift_i`)) − `pwr_ofs_i`, clamped to the range 0..63. P is the sum of y² over the interval, including its last sample.
- R8: The table entry at address a is 31 − a. The gain becomes gain + entry·2^`err_shift_i`, clamped to the range 0..65535.
- R9: `smp_o` = clamp(floor((y·g + 2^13) / 2^14)) to the 16-bit signed range. g is the applied gain. `smp_o` and `smp_vld_o` appear two cycles after the input sample.
- R10: With `gain_dly_i` = D, the applied gain is the gain word as it was D valid samples earlier. So a gain change first reaches the output D samples after the sample that follows the updating sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 16 | Signed input sample |
| smp_vld_i | input | 1 | Input sample valid |
| sync_i | input | 1 | Loop start pulse, qualified by valid |
| int_len_i | input | 24 | Samples per integration interval |
| upd_cnt_i | input | 8 | Updates per sync, 0 means unlimited |
| sync_dly_i | input | 8 | Sync delay in valid samples |
| hp_code_i | input | 3 | High-pass corner code |
| pwr_shift_i | input | 5 | Power window select |
| pwr_ofs_i | input | 6 | Offset subtracted before the table |
| err_shift_i | input | 5 | Loop gain shift on the table output |
| gain_dly_i | input | 5 | Delay of the applied gain, in samples |
| smp_o | output | 16 | Scaled, rounded, saturated sample |
| smp_vld_o | output | 1 | Output sample valid |
| gain_o | output | 16 | Current gain word, unsigned, 14 fractional bits |

## Verification
A wrong power sum, interval count or table address appears on `gain_o` at the next interval boundary. It shows as a wrong step size or a wrong step sign, two cycles after the last sample of the interval. A stuck or miscounted update counter shows as a gain that keeps moving after the expected number of steps, or stops early. Errors in the filter state or the gain delay line show on the very next `smp_o`. Tests therefore compare single output samples around a known gain step, and final gain words after counted intervals.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int IL_W   = 24;
  localparam int UC_W   = 8;
  localparam int SD_W   = 8;
  localparam int HC_W   = 3;
  localparam int PS_W   = 5;
  localparam int PO_W   = 6;
  localparam int ES_W   = 5;
  localparam int LUT_AW = 6;

  typedef struct packed {
    logic [IL_W-1:0] int_len;
    logic [UC_W-1:0] upd_cnt;
    logic [HC_W-1:0] hp_code;
    logic [PS_W-1:0] pwr_shift;
    logic [PO_W-1:0] pwr_ofs;
    logic [ES_W-1:0] err_shift;
  } agc_cfg_t;

  // descending table: low power -> positive error, high power -> negative
  function automatic logic signed [LUT_AW-1:0] err_lut(input logic [LUT_AW-1:0] a);
    logic signed [LUT_AW:0] t;
    t = $signed((LUT_AW+1)'(2**(LUT_AW-1)-1)) - $signed({1'b0, a});
    return t[LUT_AW-1:0];
  endfunction
endpackage

// File: rtl/agc_sync_dly.sv
module agc_sync_dly #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic          sync_i,
  input  logic [CW-1:0] dly_i,
  output logic          fire_o
);
  logic          pend_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    fire_o = vld_i && ((sync_i && (dly_i == '0)) ||
                       (!sync_i && pend_q && (cnt_q == CW'(1))));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (vld_i) begin
      if (sync_i) begin
        pend_q <= (dly_i != '0);
        cnt_q  <= dly_i;
      end else if (pend_q) begin
        if (cnt_q == CW'(1)) pend_q <= 1'b0;
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/agc_hpf.sv
module agc_hpf #(
  parameter int DW = 16,
  parameter int K  = 10   // must be >= 8 so every code leaves a shift of at least 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic [2:0]           code_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW-1:0] y_o
);
  localparam int AW = DW + K + 2;
  localparam logic signed [DW+1:0] YMAX = (DW+2)'(2**(DW-1)-1);
  localparam logic signed [DW+1:0] YMIN = -YMAX - (DW+2)'(1);

  logic signed [AW-1:0] dc_q, x_ext, diff, step, dc_int;
  logic signed [DW+1:0] yw;
  logic [7:0]           sh;

  always_comb begin
    sh     = 8'(K) - {5'b0, code_i};
    x_ext  = $signed({{2{x_i[DW-1]}}, x_i, {K{1'b0}}});
    diff   = x_ext - dc_q;
    step   = diff >>> sh;
    dc_int = dc_q >>> K;
    yw     = $signed({{2{x_i[DW-1]}}, x_i}) - dc_int[DW+1:0];
    if (yw > YMAX)      y_o = YMAX[DW-1:0];
    else if (yw < YMIN) y_o = YMIN[DW-1:0];
    else                y_o = yw[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dc_q <= '0;
    else if (vld_i) dc_q <= dc_q + step;
  end
endmodule

// File: rtl/agc_pwr_int.sv
module agc_pwr_int
  import agc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 2*DW + IL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 fire_i,
  input  logic signed [DW-1:0] y_i,
  input  agc_cfg_t             cfg_i,
  output logic                 upd_o,
  output logic [AW-1:0]        acc_o
);
  logic [AW-1:0]        acc_q, cur_acc;
  logic [IL_W-1:0]      cnt_q, cur_cnt;
  logic [UC_W-1:0]      rem_q, cur_rem;
  logic                 act_q, cur_act, last;
  logic signed [2*DW-1:0] ye, sq;

  always_comb begin
    ye      = $signed({{DW{y_i[DW-1]}}, y_i});
    sq      = ye * ye;
    cur_acc = fire_i ? '0 : acc_q;
    cur_cnt = fire_i ? '0 : cnt_q;
    cur_rem = fire_i ? cfg_i.upd_cnt : rem_q;
    cur_act = fire_i | act_q;
    acc_o   = cur_acc + AW'($unsigned(sq));
    last    = ((IL_W+1)'(cur_cnt) + (IL_W+1)'(1)) >= (IL_W+1)'(cfg_i.int_len);
    upd_o   = vld_i && cur_act && last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
      rem_q <= '0;
      act_q <= 1'b0;
    end else if (vld_i && cur_act) begin
      if (last) begin
        acc_q <= '0;
        cnt_q <= '0;
        if (cur_rem != '0) rem_q <= cur_rem - UC_W'(1);
        else               rem_q <= '0;
        act_q <= (cur_rem != UC_W'(1));
      end else begin
        acc_q <= acc_o;
        cnt_q <= cur_cnt + IL_W'(1);
        rem_q <= cur_rem;
        act_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/agc_gain.sv
module agc_gain
  import agc_pkg::*;
#(
  parameter int          GW    = 16,
  parameter int          AW    = 56,
  parameter int          PB    = 48,
  parameter int          DLY_W = 5,
  parameter logic [GW-1:0] GINIT = GW'(16384)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             vld_i,
  input  logic [AW-1:0]    acc_i,
  input  agc_cfg_t         cfg_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic [GW-1:0]    gain_o,
  output logic [GW-1:0]    gain_app_o
);
  localparam int DEPTH = 2**DLY_W;
  localparam int EW    = 40;
  localparam int AMAX  = 2**LUT_AW - 1;

  logic [GW-1:0]            gain_q;
  logic [GW-1:0]            line_q [DEPTH];
  logic [7:0]               sh_amt;
  logic [AW-1:0]            sel, diff;
  logic [LUT_AW-1:0]        addr;
  logic signed [LUT_AW-1:0] err;
  logic signed [EW-1:0]     delta;
  logic signed [EW:0]       sum;
  logic [GW-1:0]            gain_nx;

  always_comb begin
    sh_amt = 8'(PB) - {3'b0, cfg_i.pwr_shift};
    sel    = acc_i >> sh_amt;
    diff   = sel - AW'(cfg_i.pwr_ofs);
    if (sel < AW'(cfg_i.pwr_ofs)) addr = '0;
    else if (diff > AW'(AMAX))    addr = LUT_AW'(AMAX);
    else                          addr = diff[LUT_AW-1:0];
    err   = err_lut(addr);
    delta = $signed({{(EW-LUT_AW){err[LUT_AW-1]}}, err}) <<< cfg_i.err_shift;
    sum   = $signed({{(EW+1-GW){1'b0}}, gain_q}) + $signed({delta[EW-1], delta});
    if (sum[EW])                                    gain_nx = '0;
    else if (sum > $signed((EW+1)'(2**GW-1)))       gain_nx = '1;
    else                                            gain_nx = sum[GW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    gain_q <= GINIT;
    else if (upd_i) gain_q <= gain_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    line_q[0] <= GINIT;
    else if (vld_i) line_q[0] <= gain_q;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    line_q[i] <= GINIT;
      else if (vld_i) line_q[i] <= line_q[i-1];
    end
  end

  always_comb begin
    if (dly_i == '0) gain_app_o = gain_q;
    else             gain_app_o = line_q[dly_i - DLY_W'(1)];
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/rx_agc_loop.sv
module rx_agc_loop
  import agc_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GW    = 16,
  parameter int GFRAC = 14,
  parameter int HP_K  = 10,
  parameter int PB    = 48,
  parameter int DLY_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DW-1:0]       smp_i,
  input  logic                smp_vld_i,
  input  logic                sync_i,
  input  logic [IL_W-1:0]     int_len_i,
  input  logic [UC_W-1:0]     upd_cnt_i,
  input  logic [SD_W-1:0]     sync_dly_i,
  input  logic [HC_W-1:0]     hp_code_i,
  input  logic [PS_W-1:0]     pwr_shift_i,
  input  logic [PO_W-1:0]     pwr_ofs_i,
  input  logic [ES_W-1:0]     err_shift_i,
  input  logic [DLY_W-1:0]    gain_dly_i,
  output logic [DW-1:0]       smp_o,
  output logic                smp_vld_o,
  output logic [GW-1:0]       gain_o
);
  localparam int AW = 2*DW + IL_W;
  localparam int PW = DW + GW + 1;
  localparam logic [GW-1:0]        GINIT = GW'(2**GFRAC);
  localparam logic signed [PW-1:0] OMAX  = PW'(2**(DW-1)-1);
  localparam logic signed [PW-1:0] OMIN  = -OMAX - PW'(1);
  localparam logic signed [PW-1:0] RND   = PW'(2**(GFRAC-1));

  agc_cfg_t             cfg;
  logic                 fire_w, upd_w;
  logic signed [DW-1:0] y_w, y1_q;
  logic                 vld1_q, fire1_q;
  logic [AW-1:0]        acc_w;
  logic [GW-1:0]        gain_app;
  logic signed [PW-1:0] prod, shr;
  logic [DW-1:0]        out_q;
  logic                 out_vld_q;

  always_comb begin
    cfg.int_len   = int_len_i;
    cfg.upd_cnt   = upd_cnt_i;
    cfg.hp_code   = hp_code_i;
    cfg.pwr_shift = pwr_shift_i;
    cfg.pwr_ofs   = pwr_ofs_i;
    cfg.err_shift = err_shift_i;
  end

  agc_sync_dly #(.CW(SD_W)) u_sync (
    .clk_i, .rst_ni, .vld_i(smp_vld_i), .sync_i, .dly_i(sync_dly_i), .fire_o(fire_w)
  );

  agc_hpf #(.DW(DW), .K(HP_K)) u_hpf (
    .clk_i, .rst_ni, .vld_i(smp_vld_i), .code_i(hp_code_i),
    .x_i($signed(smp_i)), .y_o(y_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y1_q    <= '0;
      vld1_q  <= 1'b0;
      fire1_q <= 1'b0;
    end else begin
      vld1_q  <= smp_vld_i;
      fire1_q <= fire_w;
      if (smp_vld_i) y1_q <= y_w;
    end
  end

  agc_pwr_int #(.DW(DW), .AW(AW)) u_pwr (
    .clk_i, .rst_ni, .vld_i(vld1_q), .fire_i(fire1_q), .y_i(y1_q),
    .cfg_i(cfg), .upd_o(upd_w), .acc_o(acc_w)
  );

  agc_gain #(.GW(GW), .AW(AW), .PB(PB), .DLY_W(DLY_W), .GINIT(GINIT)) u_gain (
    .clk_i, .rst_ni, .upd_i(upd_w), .vld_i(vld1_q), .acc_i(acc_w), .cfg_i(cfg),
    .dly_i(gain_dly_i), .gain_o(gain_o), .gain_app_o(gain_app)
  );

  always_comb begin
    prod = $signed({{(PW-DW){y1_q[DW-1]}}, y1_q}) * $signed({{(PW-GW){1'b0}}, gain_app});
    shr  = (prod + RND) >>> GFRAC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= vld1_q;
      if (vld1_q) begin
        if (shr > OMAX)      out_q <= OMAX[DW-1:0];
        else if (shr < OMIN) out_q <= OMIN[DW-1:0];
        else                 out_q <= shr[DW-1:0];
      end
    end
  end

  assign smp_o     = out_q;
  assign smp_vld_o = out_vld_q;
endmodule

// File: rtl/rx_agc_loop_chk.sv
module rx_agc_loop_chk #(
  parameter int GW   = 16,
  parameter int IL_W = 24
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            smp_vld_i,
  input logic            smp_vld_o,
  input logic [GW-1:0]   gain_o,
  input logic [IL_W-1:0] int_len_i,
  input logic            fire_i,
  input logic            fire1_i,
  input logic            vld1_i,
  input logic            upd_i
);
  logic [1:0]      cyc_q;
  logic            seen_q;
  logic [IL_W-1:0] since_q, since_cur;

  assign since_cur = fire1_i ? '0 : since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      seen_q  <= 1'b0;
      since_q <= '0;
    end else begin
      if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
      if (fire_i) seen_q <= 1'b1;
      if (upd_i)       since_q <= '0;
      else if (vld1_i) since_q <= since_cur + IL_W'(1);
    end
  end

  // R9
  out_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (smp_vld_o == $past(smp_vld_i, 2)));

  // R8
  gain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc_q >= 2'd1) && !$stable(gain_o)) |-> $past(upd_i));

  // R2
  no_sync_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !upd_i);

  // R4
  interval_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> (({1'b0, since_cur} + (IL_W+1)'(1)) >= {1'b0, int_len_i}));

  // R4
  upd_on_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> vld1_i);
endmodule

bind rx_agc_loop rx_agc_loop_chk #(.GW(GW), .IL_W(agc_pkg::IL_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i), .smp_vld_o(smp_vld_o),
  .gain_o(gain_o), .int_len_i(int_len_i), .fire_i(fire_w), .fire1_i(fire1_q),
  .vld1_i(vld1_q), .upd_i(upd_w)
);

// File: tb/rx_agc_loop_tb_top.sv
module rx_agc_loop_tb_top;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic signed [15:0] smp_i = '0;
  logic               smp_vld_i = 1'b0;
  logic               sync_i = 1'b0;
  logic [23:0]        int_len_i;
  logic [7:0]         upd_cnt_i, sync_dly_i;
  logic [2:0]         hp_code_i;
  logic [4:0]         pwr_shift_i, err_shift_i, gain_dly_i;
  logic [5:0]         pwr_ofs_i;
  logic signed [15:0] smp_o;
  logic               smp_vld_o;
  logic [15:0]        gain_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  int out_n = 0;
  int out_q [0:255];

  always #4 clk_i = ~clk_i;

  rx_agc_loop dut_i (
    .clk_i, .rst_ni, .smp_i, .smp_vld_i, .sync_i, .int_len_i, .upd_cnt_i,
    .sync_dly_i, .hp_code_i, .pwr_shift_i, .pwr_ofs_i, .err_shift_i,
    .gain_dly_i, .smp_o, .smp_vld_o, .gain_o
  );

  always @(negedge clk_i) begin
    if (rst_ni && smp_vld_o && out_n < 256) begin
      out_q[out_n] = int'(smp_o);
      out_n++;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: cycles actual %0d expected below %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_default();
    int_len_i = 24'd4; upd_cnt_i = 8'd1; sync_dly_i = 8'd0; hp_code_i = 3'd0;
    pwr_shift_i = 5'd31; pwr_ofs_i = 6'd0; err_shift_i = 5'd0; gain_dly_i = 5'd0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; smp_vld_i = 1'b0; sync_i = 1'b0; smp_i = '0;
    repeat (2) @(negedge clk_i);
    out_n  = 0;
    rst_ni = 1'b1;
  endtask

  task automatic push(input int x, input bit s);
    @(negedge clk_i);
    smp_vld_i = 1'b1; sync_i = s; smp_i = 16'(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      smp_vld_i = 1'b0; sync_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    cfg_default(); do_reset(); idle(1);
    check("R1 gain", gain_o, 16384);
    check("R1 vld", smp_vld_o, 0);
    check("R1 smp", smp_o, 0);
  endtask

  task automatic t_no_sync();
    cfg_default(); int_len_i = 24'd1; upd_cnt_i = 8'd0; do_reset();
    for (int i = 0; i < 8; i++) push(0, 1'b0);
    idle(3);
    check("R2 gain without sync", gain_o, 16384);
    check("R9 out count", out_n, 8);
  endtask

  task automatic t_hpf();
    cfg_default(); do_reset();
    for (int i = 0; i < 20; i++) push(1000, 1'b0);
    idle(3);
    check("R6 first out code0", out_q[0], 1000);
    check("R6 slow decay code0", out_q[19] > 900, 1);
    cfg_default(); hp_code_i = 3'd7; do_reset();
    for (int i = 0; i < 20; i++) push(1000, 1'b0);
    idle(3);
    check("R6 first out code7", out_q[0], 1000);
    check("R6 fast decay code7", (out_q[19] < 100) && (out_q[19] >= 0), 1);
  endtask

  task automatic t_count();
    cfg_default(); upd_cnt_i = 8'd3; do_reset();
    push(0, 1'b1);
    for (int i = 0; i < 3; i++) push(0, 1'b0);
    idle(3);
    check("R4 first interval", gain_o, 16384 + 31);
    for (int i = 0; i < 16; i++) push(0, 1'b0);
    idle(3);
    check("R5 three updates", gain_o, 16384 + 93);
    push(0, 1'b1);
    for (int i = 0; i < 7; i++) push(0, 1'b0);
    idle(3);
    check("R5 resync reloads", gain_o, 16384 + 155);
    cfg_default(); int_len_i = 24'd0; upd_cnt_i = 8'd2; do_reset();
    push(0, 1'b1);
    for (int i = 0; i < 4; i++) push(0, 1'b0);
    idle(3);
    check("R4 zero length as one", gain_o, 16384 + 62);
  endtask

  task automatic t_free();
    cfg_default(); upd_cnt_i = 8'd0; do_reset();
    push(0, 1'b1);
    for (int i = 0; i < 39; i++) push(0, 1'b0);
    idle(3);
    check("R5 free running", gain_o, 16384 + 310);
    cfg_default(); upd_cnt_i = 8'd0; do_reset();
    push(0, 1'b1); push(0, 1'b0);
    push(0, 1'b1); push(0, 1'b0); push(0, 1'b0);
    idle(3);
    check("R5 resync clears interval", gain_o, 16384);
    push(0, 1'b0);
    idle(3);
    check("R5 interval after resync", gain_o, 16384 + 31);
  endtask

  task automatic t_sync_dly();
    cfg_default(); int_len_i = 24'd1; err_shift_i = 5'd10; do_reset();
    for (int i = 0; i < 4; i++) push(100, i == 0);
    idle(3);
    check("R3 no delay old gain", out_q[0], 100);
    check("R3 no delay new gain", out_q[1], 294);
    check("R8 gain step", gain_o, 48128);
    cfg_default(); int_len_i = 24'd1; err_shift_i = 5'd10; sync_dly_i = 8'd5; do_reset();
    for (int i = 0; i < 8; i++) push(100, i == 0);
    idle(3);
    check("R3 delayed old gain", out_q[5], 100);
    check("R3 delayed new gain", out_q[6], 294);
  endtask

  task automatic t_gain_dly();
    cfg_default(); int_len_i = 24'd1; err_shift_i = 5'd10; gain_dly_i = 5'd3; do_reset();
    for (int i = 0; i < 7; i++) push(100, i == 0);
    idle(3);
    check("R10 held gain", out_q[3], 100);
    check("R10 delayed gain", out_q[4], 294);
  endtask

  task automatic run_pwr(input int ofs, input int shift, input int exp, input string req);
    cfg_default(); int_len_i = 24'd8; pwr_ofs_i = 6'(ofs); pwr_shift_i = 5'(shift); do_reset();
    for (int i = 0; i < 8; i++) push((i % 2 == 0) ? 815 : -815, i == 0);
    idle(3);
    check(req, gain_o, exp);
  endtask

  task automatic t_addr();
    run_pwr(10, 31, 16384 + 1, "R7 offset 10");
    run_pwr(0, 31, 16384 - 9, "R7 offset 0");
    run_pwr(0, 30, 16384 + 11, "R7 shift 30");
  endtask

  task automatic t_sat();
    cfg_default(); int_len_i = 24'd1; err_shift_i = 5'd14; do_reset();
    push(0, 1'b1); push(30000, 1'b0); push(-30000, 1'b0);
    idle(3);
    check("R8 high clamp", gain_o, 65535);
    check("R9 positive clamp", out_q[1], 32767);
    check("R9 negative clamp", out_q[2], -32768);
    cfg_default(); int_len_i = 24'd2; upd_cnt_i = 8'd0; err_shift_i = 5'd10; do_reset();
    for (int i = 0; i < 6; i++) push((i % 2 == 0) ? 16000 : -16000, i == 0);
    idle(3);
    check("R8 low clamp", gain_o, 0);
    check("R9 unity pass", out_q[0], 16000);
    check("R9 zero gain out", out_q[5], 0);
  endtask

  initial begin
    cfg_default();
    t_reset();
    t_no_sync();
    t_hpf();
    t_count();
    t_free();
    t_sync_dly();
    t_gain_dly();
    t_addr();
    t_sat();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule